// File: doc/BRIEF.md
# Bidirectional Charge-Unit Prescaler with Interrupt Latch

This block is the digital back end of a coulomb counter. An analog integrator outside the block reverses its ramp each time a fixed small quantum of charge has passed. Each reversal arrives here as a one-cycle strobe, together with the sign of the battery current at that moment. An up/down prescale counter absorbs these reversals. Every time the counter wraps past its top or its bottom, the block reports one charge unit to a host. It does this through an active-low interrupt line and a polarity line. Both lines are open-drain, and are modelled here as pull-down enables.

The host answers each interrupt with a low pulse on a clear input. The clear input is synchronised, and its low time is measured in clock cycles. A qualified pulse releases the interrupt and unfreezes the polarity line. While unfrozen, the polarity line shows the direction of the most recent reversal. The counter never stops for the host. A second wrap that arrives before the host clears is not reported, and instead sets a sticky lost-unit flag.

Three conditions wipe all state: a shutdown input, an undervoltage input and the power-on reset. Once the block leaves any of them, it ignores reversals for a programmable initialisation interval.

Top module: `chargeUnitPrescaler`

## Requirements
- R1: While `rstN` is low and right after it, `intSink`, `polSink` and `lostUnit` are 0, which means the polarity line rests at "charging". The prescale counter starts at mid-scale, 2^(CNT_W-1).
- R2: After reset, and after leaving shutdown or undervoltage, reversal strobes are ignored until INIT_CYCLES clock edges have passed. The first strobe that counts is the one sampled on edge INIT_CYCLES+1.
- R3: Each accepted strobe with `revDir`=1 (charging) adds one to the counter, and each accepted strobe with `revDir`=0 subtracts one. An up-step from all-ones or a down-step from zero is a wrap. From mid-scale, the first charge wrap comes on the 2^(CNT_W-1)-th charge strobe. The first discharge wrap comes on the (2^(CNT_W-1)+1)-th discharge strobe.
- R4: A wrap while no interrupt is held sets `intSink`=1 after that edge. The same edge freezes the polarity to the wrapping strobe's direction, with `polSink`=1 for discharge and 0 for charge. The frozen polarity does not change while the interrupt is held.
- R5: While no interrupt is held, `polSink` is the inverse of the direction of the last accepted strobe.
- R6: `clearN` passes through two flops. The interrupt is released on the edge at which the synchronised clear has been low for CLR_MIN consecutive edges. From the first edge that samples `clearN` low, this is edge CLR_MIN+2. Shorter low pulses leave the interrupt held.
- R7: The counter keeps counting while the interrupt is held and while `clearN` is low.
- R8: A wrap while the interrupt is held and not being released this cycle is dropped. It sets `lostUnit`=1, which stays set until the next reset, shutdown or undervoltage.
- R9: If a wrap lands on the same edge as a release, the interrupt stays held and the polarity takes the new wrap's direction.
- R10: While `shutdownN` is low, `intSink` and `polSink` are 0 at once, without waiting for a clock edge. All state returns to the R1 values, and the R2 hold-off restarts.
- R11: A clock edge that samples `uvLow`=1 returns all state to the R1 values, including `lostUnit`, and restarts the R2 hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| uvLow | input | 1 | Supply-below-threshold indication; wipes all state on a clock edge |
| shutdownN | input | 1 | Shutdown, active low; releases both outputs and wipes all state |
| revStrobe | input | 1 | One-cycle integrator ramp-reversal event |
| revDir | input | 1 | Direction tagged to `revStrobe`: 1 = charge into battery, 0 = charge out |
| clearN | input | 1 | Host interrupt clear, active low, asynchronous to `clk` |
| intSink | output | 1 | Pull-down enable for the interrupt line (1 = interrupt asserted) |
| polSink | output | 1 | Pull-down enable for the polarity line (1 = discharging) |
| lostUnit | output | 1 | Sticky flag: a charge unit was dropped while the interrupt was held |

## Verification
The prescale count is not visible at the ports, so a wrong count first shows up as an interrupt on the wrong strobe. With the bench's 4-bit counter, that becomes visible within sixteen reversals. A latch or polarity register that is wrong shows up on the next edge as a mismatch on `intSink` or `polSink`. A fault in the clear qualifier shows up CLR_MIN+2 edges after the clear falls, as a release that comes early, late or never. The bench compares every output on every cycle against a behavioural model. Because of this, a state error is caught on the first cycle in which it reaches a pin.

// File: rtl/cupPkg.sv
package cupPkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wipe;    // synchronous return to the reset state
    logic stepEn;  // accept the current reversal into the counter
  } cupStrobeT;

  typedef enum logic {
    LAT_FREE = 1'b0,
    LAT_HELD = 1'b1
  } cupLatchT;

endpackage

// File: rtl/cupClearQual.sv
module cupClearQual #(
  parameter int CLR_MIN = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic wipe,
  input  logic clearN,
  output logic relFire
);
  localparam int LOW_W = $clog2(CLR_MIN + 1);
  localparam logic [LOW_W-1:0] LOW_FIRE = LOW_W'(CLR_MIN - 1);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(CLR_MIN);

  logic syncA, syncB;
  logic [LOW_W-1:0] lowCnt;

  // One-shot: fires on the edge that completes CLR_MIN synchronised low samples.
  assign relFire = !syncB && (lowCnt == LOW_FIRE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      syncB  <= 1'b1;
      lowCnt <= '0;
    end else if (wipe) begin
      syncA  <= 1'b1;
      syncB  <= 1'b1;
      lowCnt <= '0;
    end else begin
      syncA <= clearN;
      syncB <= syncA;
      if (syncB)
        lowCnt <= '0;
      else if (lowCnt != LOW_SAT)
        lowCnt <= lowCnt + LOW_W'(1);
    end
  end
endmodule

// File: rtl/cupDatapath.sv
module cupDatapath
  import cupPkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int INIT_CYCLES = 1000000
) (
  input  logic      clk,
  input  logic      rstN,
  input  cupStrobeT strb,
  input  logic      revDir,
  output logic      wrap,
  output logic      wrapDir,
  output logic      curDir,
  output logic      ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] count;
  logic atEdge;

  assign atEdge  = revDir ? (count == CNT_MAX) : (count == '0);
  assign wrap    = strb.stepEn && atEdge;
  assign wrapDir = revDir;

  // Prescale counter and live direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= CNT_MID;
      curDir <= 1'b1;
    end else if (strb.wipe) begin
      count  <= CNT_MID;
      curDir <= 1'b1;
    end else if (strb.stepEn) begin
      count  <= revDir ? count + CNT_W'(1) : count - CNT_W'(1);
      curDir <= revDir;
    end
  end

  // Start-up hold-off timer.
  generate
    if (INIT_CYCLES == 0) begin : g_noHold
      assign ready = 1'b1;
    end else begin : g_hold
      localparam int INIT_W = $clog2(INIT_CYCLES + 1);
      localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES);
      logic [INIT_W-1:0] initCnt;
      assign ready = (initCnt == INIT_LAST);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          initCnt <= '0;
        else if (strb.wipe)
          initCnt <= '0;
        else if (!ready)
          initCnt <= initCnt + INIT_W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/cupControl.sv
module cupControl
  import cupPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      uvLow,
  input  logic      shutdownN,
  input  logic      revStrobe,
  input  logic      ready,
  input  logic      wrap,
  input  logic      wrapDir,
  input  logic      relFire,
  output cupStrobeT strb,
  output logic      intLatched,
  output logic      polLatched,
  output logic      lostUnit
);
  cupLatchT latState;
  logic wipe;

  assign wipe        = uvLow || !shutdownN;
  assign strb.wipe   = wipe;
  assign strb.stepEn = revStrobe && ready && !wipe;
  assign intLatched  = (latState == LAT_HELD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latState   <= LAT_FREE;
      polLatched <= 1'b1;
      lostUnit   <= 1'b0;
    end else if (wipe) begin
      latState   <= LAT_FREE;
      polLatched <= 1'b1;
      lostUnit   <= 1'b0;
    end else begin
      unique case (latState)
        LAT_FREE: begin
          if (wrap) begin
            latState   <= LAT_HELD;
            polLatched <= wrapDir;
          end
        end
        LAT_HELD: begin
          if (wrap && relFire) begin
            polLatched <= wrapDir;        // new unit wins over the release
          end else if (wrap) begin
            lostUnit <= 1'b1;             // unit dropped, still held
          end else if (relFire) begin
            latState <= LAT_FREE;
          end
        end
        default: latState <= LAT_FREE;
      endcase
    end
  end
endmodule

// File: rtl/chargeUnitPrescaler.sv
module chargeUnitPrescaler
  import cupPkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int INIT_CYCLES = 1000000,
  parameter int CLR_MIN     = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic uvLow,
  input  logic shutdownN,
  input  logic revStrobe,
  input  logic revDir,
  input  logic clearN,
  output logic intSink,
  output logic polSink,
  output logic lostUnit
);
  cupStrobeT strb;
  logic wrap, wrapDir, curDir, ready, relFire;
  logic intLatched, polLatched, polLevel;

  cupClearQual #(.CLR_MIN(CLR_MIN)) clrQ (
    .clk(clk), .rstN(rstN), .wipe(strb.wipe), .clearN(clearN), .relFire(relFire)
  );

  cupDatapath #(.CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .revDir(revDir),
    .wrap(wrap), .wrapDir(wrapDir), .curDir(curDir), .ready(ready)
  );

  cupControl ctl (
    .clk(clk), .rstN(rstN), .uvLow(uvLow), .shutdownN(shutdownN),
    .revStrobe(revStrobe), .ready(ready), .wrap(wrap), .wrapDir(wrapDir),
    .relFire(relFire), .strb(strb), .intLatched(intLatched),
    .polLatched(polLatched), .lostUnit(lostUnit)
  );

  // Open-drain enables: released (high-Z) while shut down.
  assign polLevel = intLatched ? polLatched : curDir;
  assign intSink  = shutdownN && intLatched;
  assign polSink  = shutdownN && !polLevel;
endmodule

// File: rtl/chargeUnitPrescalerChk.sv
module chargeUnitPrescalerChk (
  input logic clk,
  input logic rstN,
  input logic uvLow,
  input logic shutdownN,
  input logic intSink,
  input logic polSink,
  input logic lostUnit,
  input logic wrap,
  input logic relFire
);
  // R10
  shutdown_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownN |-> (!intSink && !polSink));

  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lostUnit && shutdownN && !uvLow) |=> lostUnit);

  // R11
  uv_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvLow |=> (!intSink && !lostUnit));

  // R4
  int_from_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intSink) |-> $past(wrap));

  // R4 R9
  pol_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intSink && $past(intSink)) |-> ($stable(polSink) || $past(relFire)));

  // R6
  release_by_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(intSink) && shutdownN) |-> ($past(relFire) || $past(uvLow)));
endmodule

bind chargeUnitPrescaler chargeUnitPrescalerChk chk (
  .clk(clk), .rstN(rstN), .uvLow(uvLow), .shutdownN(shutdownN),
  .intSink(intSink), .polSink(polSink), .lostUnit(lostUnit),
  .wrap(wrap), .relFire(relFire)
);

// File: tb/chargeUnitPrescaler_test.sv
`timescale 1ns/1ps
module chargeUnitPrescaler_test;
  localparam int CNT_W = 4;
  localparam int INIT_CYCLES = 20;
  localparam int CLR_MIN = 5;
  localparam int TOP = (1 << CNT_W) - 1;
  localparam int MID = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvLow = 1'b0;
  logic shutdownN = 1'b1;
  logic revStrobe = 1'b0;
  logic revDir = 1'b1;
  logic clearN = 1'b1;
  logic intSink, polSink, lostUnit;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  chargeUnitPrescaler #(.CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES), .CLR_MIN(CLR_MIN)) uut (
    .clk(clk), .rstN(rstN), .uvLow(uvLow), .shutdownN(shutdownN),
    .revStrobe(revStrobe), .revDir(revDir), .clearN(clearN),
    .intSink(intSink), .polSink(polSink), .lostUnit(lostUnit)
  );

  // Behavioural reference model.
  int mCnt = MID, mInit = 0, mLow = 0;
  bit mHeld = 0, mPol = 1, mLost = 0, mCur = 1, mS1 = 1, mS2 = 1;

  task automatic modelWipe();
    mCnt = MID; mInit = 0; mLow = 0;
    mHeld = 0; mPol = 1; mLost = 0; mCur = 1; mS1 = 1; mS2 = 1;
  endtask

  always @(posedge clk) begin
    if (!rstN || uvLow || !shutdownN) begin
      modelWipe();
    end else begin
      bit rel, acc, wr;
      rel = (mS2 == 0) && (mLow == CLR_MIN - 1);
      acc = (mInit == INIT_CYCLES) && revStrobe;
      wr = 0;
      if (acc) begin
        if (revDir) begin
          if (mCnt == TOP) begin wr = 1; mCnt = 0; end else mCnt++;
        end else begin
          if (mCnt == 0) begin wr = 1; mCnt = TOP; end else mCnt--;
        end
        mCur = revDir;
      end
      if (wr) begin
        if (mHeld && !rel) mLost = 1;
        else begin mHeld = 1; mPol = revDir; end
      end else if (rel) mHeld = 0;
      mLow = mS2 ? 0 : ((mLow < CLR_MIN) ? mLow + 1 : mLow);
      mS2 = mS1;
      mS1 = clearN;
      if (mInit < INIT_CYCLES) mInit++;
    end
  end

  task automatic cmp(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    bit eInt, ePol;
    eInt = shutdownN && mHeld;
    ePol = shutdownN && !(mHeld ? mPol : mCur);
    cmp("model intSink", intSink, eInt);
    cmp("model polSink", polSink, ePol);
    cmp("model lostUnit", lostUnit, mLost);
  end

  task automatic tick(input logic r, input logic d);
    revStrobe = r;
    revDir = d;
    @(posedge clk);
    #1;
    revStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1);
  endtask

  task automatic revs(input int n, input logic d);
    for (int i = 0; i < n; i++) tick(1'b1, d);
  endtask

  task automatic fullClear();
    clearN = 1'b0;
    idle(6);
    clearN = 1'b1;
    idle(3);
  endtask

  initial begin
    logic [15:0] lfsr;
    idle(3);
    tag = "R1";
    cmp("reset intSink", intSink, 1'b0);
    cmp("reset polSink", polSink, 1'b0);
    cmp("reset lostUnit", lostUnit, 1'b0);
    rstN = 1'b1;

    // R2: strobes during hold-off are ignored
    tag = "R2";
    revs(5, 1'b0);
    idle(25);
    tag = "R3";
    revs(MID - 1, 1'b1);
    cmp("R3 no wrap before mid-scale", intSink, 1'b0);
    revs(1, 1'b1);
    tag = "R4";
    cmp("R2 R3 charge wrap asserts interrupt", intSink, 1'b1);
    cmp("R4 charge polarity latched", polSink, 1'b0);

    // R7: counting continues while held and while clear is low
    tag = "R7";
    revs(3, 1'b1);
    clearN = 1'b0;
    revs(6, 1'b1);
    clearN = 1'b1;
    idle(3);
    tag = "R6";
    cmp("R6 qualified clear releases", intSink, 1'b0);
    tag = "R5";
    cmp("R5 free polarity charging", polSink, 1'b0);
    tag = "R7";
    revs(6, 1'b1);
    cmp("R7 not yet wrapped", intSink, 1'b0);
    revs(1, 1'b1);
    cmp("R7 wrap counts steps taken during clear", intSink, 1'b1);

    // R6: short clear pulse ignored
    tag = "R6";
    clearN = 1'b0;
    idle(3);
    clearN = 1'b1;
    idle(6);
    cmp("R6 short pulse ignored", intSink, 1'b1);

    // R8: wrap while held is lost
    tag = "R8";
    revs(1, 1'b0);
    cmp("R8 lost flag set", lostUnit, 1'b1);
    cmp("R8 interrupt still held", intSink, 1'b1);
    cmp("R8 polarity stays frozen", polSink, 1'b0);
    fullClear();
    cmp("R8 lost flag sticky", lostUnit, 1'b1);
    tag = "R5";
    cmp("R5 free polarity discharging", polSink, 1'b1);

    // R9: wrap on the release edge
    tag = "R9";
    revs(1, 1'b1);
    clearN = 1'b0;
    idle(6);
    clearN = 1'b1;
    revs(1, 1'b0);
    cmp("R9 interrupt stays held", intSink, 1'b1);
    cmp("R9 polarity takes new unit", polSink, 1'b1);

    // R10: shutdown
    tag = "R10";
    shutdownN = 1'b0;
    #1;
    cmp("R10 interrupt released at once", intSink, 1'b0);
    cmp("R10 polarity released at once", polSink, 1'b0);
    idle(3);
    shutdownN = 1'b1;
    #0.1;
    cmp("R10 lost flag wiped", lostUnit, 1'b0);
    revs(9, 1'b0);
    idle(15);
    revs(MID, 1'b0);
    cmp("R10 hold-off restarted, no wrap yet", intSink, 1'b0);
    revs(1, 1'b0);
    cmp("R10 R3 discharge wrap", intSink, 1'b1);
    cmp("R10 discharge polarity", polSink, 1'b1);

    // R11: undervoltage wipe
    tag = "R11";
    revs(1, 1'b1);
    cmp("R11 lost before wipe", lostUnit, 1'b1);
    uvLow = 1'b1;
    idle(1);
    uvLow = 1'b0;
    cmp("R11 interrupt wiped", intSink, 1'b0);
    cmp("R11 lost wiped", lostUnit, 1'b0);
    cmp("R11 polarity back to charging", polSink, 1'b0);
    idle(25);

    // R3: mixed traffic against the model
    tag = "R3";
    lfsr = 16'hACE1;
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 8 == 0) clearN = lfsr[7] | lfsr[3];
      tick(lfsr[0] | lfsr[5], lfsr[2] ^ (i > 400));
    end
    clearN = 1'b1;
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule